// File: doc/BRIEF.md
# Position-form PID controller with filtered derivative

This block computes a full (absolute) control value once per sample. Each sample carries a setpoint, a measurement and four precomputed fixed-point coefficients. From these it forms the error and updates two kept states: a running integral and a derivative band-limited by its own first-order pole. It then sums the proportional term with both states and saturates the result to the output width. The new control value appears on the output together with a one-cycle completion pulse. It stays unchanged until the next sample has been processed.

The sample input is a valid/ready stream. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so a sample offered while a previous one is still in flight waits. The offering side must keep the sample and all coefficients stable until the handshake. The output side has no back-pressure: the value is held and `done_out` marks the cycle in which it changed.

All quantities are two's complement. Coefficients carry `FRAC_W` (default 12) fractional bits. Every coefficient product is reduced by an arithmetic right shift of `FRAC_W` bits, which rounds toward minus infinity. The coefficient inputs are: a proportional gain; an integral step gain (proportional gain times sample period over integral time); a derivative decay factor (filter time over period-plus-filter time); and a derivative gain (proportional gain times derivative time over period-plus-filter time).

Top module: `pid_position_ctrl`

## Requirements
- R1: After a synchronous reset the control output is 0, `done_out` is 0, `in_ready` is 1, and the integral state, derivative state and stored previous error are all zero.
- R2: A sample is consumed only on an edge with `in_valid` and `in_ready` both high. `in_ready` stays low for the two cycles that follow, and inputs presented or changed during those cycles (coefficients included) do not affect the result of the sample in flight.
- R3: `done_out` is high for exactly one cycle, three edges after the accepting edge. `ctrl_out` changes only in that cycle and holds its value at all other times.
- R4: The error is setpoint minus measurement, and the proportional term is (kprop * e) >>> FRAC_W.
- R5: The integral state grows by (kint * e) >>> FRAC_W on each sample whose output is not saturated.
- R6: The derivative state becomes ((kdecay * ud_old) + kderiv * (e - e_prev)) >>> FRAC_W, where e_prev is the error of the previous accepted sample (zero after reset).
- R7: The control value is p + ui + ud, saturated to the signed range of `OUT_W` bits (default -32768 to 32767).
- R8: If the sum formed with the updated integral falls outside the output range, the integral keeps its old value. The output is then the saturated sum formed with that old integral.
- R9: The integral and derivative states are each saturated to the signed range of `STATE_W` bits (default 24) when updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| setpt_in | input | DATA_W | Setpoint, signed |
| meas_in | input | DATA_W | Measurement, signed |
| kprop_in | input | COEF_W | Proportional gain, signed fixed point |
| kint_in | input | COEF_W | Integral step gain, signed fixed point |
| kdecay_in | input | COEF_W | Derivative decay factor, signed fixed point |
| kderiv_in | input | COEF_W | Derivative gain, signed fixed point |
| ctrl_out | output | OUT_W | Held control value, signed |
| done_out | output | 1 | One-cycle pulse when ctrl_out is updated |

## Verification
The hardest state to reach from the ports is the derivative state at its storage limit. The output saturates long before that limit, so the clamp is invisible at `ctrl_out` while it acts. The stimulus drives a decay factor well above one with a steady error step, so the derivative state diverges into the clamp. It then switches to a factor of one half with zero error change, so the state halves each sample until the output leaves saturation. There the exact values reveal whether the clamp value was right. The integral freeze is brought out the same way: several saturated samples are followed by a small reversed error, whose unsaturated output exposes the integral that was kept.

// File: rtl/pid_pkg.sv
package pid_pkg;
  // Pipeline phase of one sample through the controller
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ERR  = 2'd1,
    PH_MUL  = 2'd2
  } pid_phase_e;

  // Default geometry shared by the modules
  localparam int PID_DATA_W  = 16;
  localparam int PID_COEF_W  = 16;
  localparam int PID_FRAC_W  = 12;
  localparam int PID_STATE_W = 24;
  localparam int PID_OUT_W   = 16;

  function automatic int pid_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pid_sat.sv
// Signed saturation of a wide value into a narrower signed range
module pid_sat #(
  parameter int IN_W  = 34,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int EXT_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] HI_V = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO_V = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > HI_V)      dout = HI_V[OUT_W-1:0];
    else if (din < LO_V) dout = LO_V[OUT_W-1:0];
    else                 dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/pid_err_stage.sv
// Forms the error and its first difference; keeps the previous error
module pid_err_stage #(
  parameter int DATA_W = 16,
  localparam int ERR_W = DATA_W + 1,
  localparam int DIF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] setpt,
  input  logic signed [DATA_W-1:0] meas,
  output logic signed [ERR_W-1:0]  err_q,
  output logic signed [DIF_W-1:0]  derr_q
);
  logic signed [ERR_W-1:0] err_n;
  logic signed [ERR_W-1:0] err_prev_q;

  always_comb err_n = ERR_W'(setpt) - ERR_W'(meas);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q      <= '0;
      derr_q     <= '0;
      err_prev_q <= '0;
    end else if (load) begin
      err_q      <= err_n;
      derr_q     <= DIF_W'(err_n) - DIF_W'(err_prev_q);
      err_prev_q <= err_n;
    end
  end
endmodule

// File: rtl/pid_mul_stage.sv
// Coefficient products: proportional, integral step and derivative recursion
module pid_mul_stage #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 12,
  parameter int STATE_W = 24,
  localparam int ERR_W  = DATA_W + 1,
  localparam int DIF_W  = DATA_W + 2,
  localparam int PROD_W = ERR_W + COEF_W,
  localparam int DER_W  = COEF_W + STATE_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic signed [ERR_W-1:0]   err,
  input  logic signed [DIF_W-1:0]   derr,
  input  logic signed [COEF_W-1:0]  kprop,
  input  logic signed [COEF_W-1:0]  kint,
  input  logic signed [COEF_W-1:0]  kdecay,
  input  logic signed [COEF_W-1:0]  kderiv,
  input  logic signed [STATE_W-1:0] ud_state,
  output logic signed [PROD_W-1:0]  p_q,
  output logic signed [PROD_W-1:0]  i_q,
  output logic signed [STATE_W-1:0] udn_q
);
  logic signed [PROD_W-1:0]  prop_full;
  logic signed [PROD_W-1:0]  int_full;
  logic signed [DER_W-1:0]   der_full;
  logic signed [DER_W-1:0]   der_shift;
  logic signed [STATE_W-1:0] udn_c;

  always_comb begin
    prop_full = PROD_W'(kprop) * PROD_W'(err);
    int_full  = PROD_W'(kint) * PROD_W'(err);
    der_full  = DER_W'(kdecay) * DER_W'(ud_state) + DER_W'(kderiv) * DER_W'(derr);
    der_shift = der_full >>> FRAC_W;
  end

  pid_sat #(.IN_W(DER_W), .OUT_W(STATE_W)) u_ud_sat (
    .din  (der_shift),
    .dout (udn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q   <= '0;
      i_q   <= '0;
      udn_q <= '0;
    end else if (load) begin
      p_q   <= prop_full >>> FRAC_W;
      i_q   <= int_full >>> FRAC_W;
      udn_q <= udn_c;
    end
  end
endmodule

// File: rtl/pid_acc_stage.sv
// Integral update with freeze, derivative commit, output sum and saturation
module pid_acc_stage #(
  parameter int PROD_W  = 33,
  parameter int STATE_W = 24,
  parameter int OUT_W   = 16,
  localparam int IW     = pid_pkg::pid_max(PROD_W, STATE_W) + 1,
  localparam int TW     = IW + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic signed [PROD_W-1:0]  p_in,
  input  logic signed [PROD_W-1:0]  i_in,
  input  logic signed [STATE_W-1:0] udn_in,
  output logic signed [OUT_W-1:0]   ctrl_q,
  output logic signed [STATE_W-1:0] ud_q,
  output logic                      done_q
);
  logic signed [STATE_W-1:0] ui_q;
  logic signed [IW-1:0]      ui_sum;
  logic signed [STATE_W-1:0] ui_cand;
  logic signed [TW-1:0]      trial_sum;
  logic signed [TW-1:0]      kept_sum;
  logic signed [OUT_W-1:0]   trial_sat;
  logic signed [OUT_W-1:0]   kept_sat;
  logic                      trial_clip;

  always_comb ui_sum = IW'(ui_q) + IW'(i_in);

  pid_sat #(.IN_W(IW), .OUT_W(STATE_W)) u_ui_sat (
    .din  (ui_sum),
    .dout (ui_cand)
  );

  always_comb begin
    trial_sum = TW'(p_in) + TW'(ui_cand) + TW'(udn_in);
    kept_sum  = TW'(p_in) + TW'(ui_q) + TW'(udn_in);
  end

  pid_sat #(.IN_W(TW), .OUT_W(OUT_W)) u_trial_sat (
    .din  (trial_sum),
    .dout (trial_sat)
  );

  pid_sat #(.IN_W(TW), .OUT_W(OUT_W)) u_kept_sat (
    .din  (kept_sum),
    .dout (kept_sat)
  );

  always_comb trial_clip = (TW'(trial_sat) != trial_sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      ui_q   <= '0;
      ud_q   <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load;
      if (load) begin
        ud_q <= udn_in;
        if (trial_clip) begin
          ctrl_q <= kept_sat;
        end else begin
          ui_q   <= ui_cand;
          ctrl_q <= trial_sat;
        end
      end
    end
  end
endmodule

// File: rtl/pid_position_ctrl.sv
module pid_position_ctrl
  import pid_pkg::*;
#(
  parameter int DATA_W  = PID_DATA_W,
  parameter int COEF_W  = PID_COEF_W,
  parameter int FRAC_W  = PID_FRAC_W,
  parameter int STATE_W = PID_STATE_W,
  parameter int OUT_W   = PID_OUT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] setpt_in,
  input  logic signed [DATA_W-1:0] meas_in,
  input  logic signed [COEF_W-1:0] kprop_in,
  input  logic signed [COEF_W-1:0] kint_in,
  input  logic signed [COEF_W-1:0] kdecay_in,
  input  logic signed [COEF_W-1:0] kderiv_in,
  output logic signed [OUT_W-1:0]  ctrl_out,
  output logic                     done_out
);
  localparam int ERR_W  = DATA_W + 1;
  localparam int DIF_W  = DATA_W + 2;
  localparam int PROD_W = ERR_W + COEF_W;
  localparam int NCOEF  = 4;

  pid_phase_e phase_q;
  logic       accept;

  logic signed [COEF_W-1:0]  coef_in [NCOEF];
  logic signed [COEF_W-1:0]  coef_q  [NCOEF];
  logic signed [ERR_W-1:0]   err;
  logic signed [DIF_W-1:0]   derr;
  logic signed [PROD_W-1:0]  p_term;
  logic signed [PROD_W-1:0]  i_term;
  logic signed [STATE_W-1:0] ud_next;
  logic signed [STATE_W-1:0] ud_state;

  assign in_ready = (phase_q == PH_IDLE);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) phase_q <= PH_ERR;
        PH_ERR:  phase_q <= PH_MUL;
        PH_MUL:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign coef_in[0] = kprop_in;
  assign coef_in[1] = kint_in;
  assign coef_in[2] = kdecay_in;
  assign coef_in[3] = kderiv_in;

  // Coefficients are taken with the sample so later input changes cannot leak in
  for (genvar g = 0; g < NCOEF; g++) begin : g_coef
    always_ff @(posedge clk) begin
      if (rst)         coef_q[g] <= '0;
      else if (accept) coef_q[g] <= coef_in[g];
    end
  end

  pid_err_stage #(.DATA_W(DATA_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .setpt  (setpt_in),
    .meas   (meas_in),
    .err_q  (err),
    .derr_q (derr)
  );

  pid_mul_stage #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .STATE_W(STATE_W)
  ) u_mul (
    .clk      (clk),
    .rst      (rst),
    .load     (phase_q == PH_ERR),
    .err      (err),
    .derr     (derr),
    .kprop    (coef_q[0]),
    .kint     (coef_q[1]),
    .kdecay   (coef_q[2]),
    .kderiv   (coef_q[3]),
    .ud_state (ud_state),
    .p_q      (p_term),
    .i_q      (i_term),
    .udn_q    (ud_next)
  );

  pid_acc_stage #(
    .PROD_W (PROD_W),
    .STATE_W(STATE_W),
    .OUT_W  (OUT_W)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .load   (phase_q == PH_MUL),
    .p_in   (p_term),
    .i_in   (i_term),
    .udn_in (ud_next),
    .ctrl_q (ctrl_out),
    .ud_q   (ud_state),
    .done_q (done_out)
  );
endmodule

// File: rtl/pid_position_ctrl_chk.sv
module pid_position_ctrl_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done_out,
  input logic [OUT_W-1:0] ctrl_out
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_out == '0 && !done_out && in_ready));

  // R2
  busy_first_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !in_ready);

  // R2
  busy_second_chk: assert property (@(posedge clk) disable iff (rst)
    $past(acc, 2) |-> !in_ready);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_out |-> $past(acc, 3));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_out |=> !done_out);

  // R3
  hold_output_chk: assert property (@(posedge clk) disable iff (rst)
    !done_out |-> $stable(ctrl_out));
endmodule

bind pid_position_ctrl pid_position_ctrl_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done_out (done_out),
  .ctrl_out (ctrl_out)
);

// File: tb/pid_position_ctrl_bench.sv
module pid_position_ctrl_bench;
  localparam int DATA_W  = 16;
  localparam int COEF_W  = 16;
  localparam int FRAC_W  = 12;
  localparam int STATE_W = 24;
  localparam int OUT_W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DATA_W-1:0] setpt = '0, meas = '0;
  logic signed [COEF_W-1:0] kprop = '0, kint = '0, kdecay = '0, kderiv = '0;
  logic signed [OUT_W-1:0]  ctrl_out;
  logic done_out;

  always #10 clk = ~clk;

  pid_position_ctrl #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .STATE_W(STATE_W), .OUT_W(OUT_W)
  ) u_pid_position_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .setpt_in(setpt), .meas_in(meas), .kprop_in(kprop), .kint_in(kint),
    .kdecay_in(kdecay), .kderiv_in(kderiv), .ctrl_out(ctrl_out), .done_out(done_out)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  longint m_ui, m_ud, m_eprev, m_res, m_u;
  int     m_cnt;
  bit     m_done;

  function automatic longint clampw(input longint v, input int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_take();
    longint e, de, p, it, udn, uic, t;
    e   = longint'(setpt) - longint'(meas);
    de  = e - m_eprev;
    m_eprev = e;
    p   = (longint'(kprop) * e) >>> FRAC_W;
    it  = (longint'(kint) * e) >>> FRAC_W;
    udn = clampw((longint'(kdecay) * m_ud + longint'(kderiv) * de) >>> FRAC_W, STATE_W);
    uic = clampw(m_ui + it, STATE_W);
    t   = p + uic + udn;
    if (t == clampw(t, OUT_W)) begin
      m_ui  = uic;
      m_res = t;
    end else begin
      m_res = clampw(p + m_ui + udn, OUT_W);
    end
    m_ud = udn;
  endtask

  // One clock: model advances at the edge, outputs compared at the falling edge
  task automatic do_cycle(input string req);
    bit take;
    take = in_valid && (m_cnt == 0);
    @(posedge clk);
    m_done = 0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_done = 1;
        m_u = m_res;
      end
    end
    if (take) begin
      model_take();
      m_cnt = 2;
    end
    @(negedge clk);
    check(req, longint'(ctrl_out), m_u);
    check("R3", longint'(done_out), longint'(m_done));
    check("R2", longint'(in_ready), longint'(m_cnt == 0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_ui = 0; m_ud = 0; m_eprev = 0; m_res = 0; m_u = 0; m_cnt = 0; m_done = 0;
    check("R1", longint'(ctrl_out), 0);
    check("R1", longint'(done_out), 0);
    check("R1", longint'(in_ready), 1);
  endtask

  task automatic offer(input int sp, input int ms, input string req);
    bit took;
    setpt = DATA_W'(sp);
    meas  = DATA_W'(ms);
    in_valid = 1'b1;
    took = 0;
    while (!took) begin
      took = (m_cnt == 0);
      do_cycle(req);
    end
  endtask

  task automatic drain(input string req);
    while (m_cnt > 0) do_cycle(req);
    do_cycle(req);
  endtask

  task automatic sample(input int sp, input int ms, input string req);
    offer(sp, ms, req);
    in_valid = 1'b0;
    drain(req);
  endtask

  task automatic set_coef(input int kp, input int ki, input int kl, input int kd);
    kprop = COEF_W'(kp); kint = COEF_W'(ki); kdecay = COEF_W'(kl); kderiv = COEF_W'(kd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();

    // R4 proportional path, including floor rounding of a negative product
    set_coef(4096, 0, 0, 0);
    sample(1000, 200, "R4");
    sample(-300, 500, "R4");
    set_coef(2048, 0, 0, 0);
    sample(0, 7, "R4");
    sample(-32768, 32767, "R4");

    // R5 integral accumulation
    do_reset();
    set_coef(0, 1024, 0, 0);
    for (int i = 0; i < 4; i++) sample(100, 0, "R5");
    sample(0, 3, "R5");

    // R6 filtered derivative recursion
    do_reset();
    set_coef(0, 0, 2048, 4096);
    sample(0, 0, "R6");
    sample(400, 0, "R6");
    sample(400, 0, "R6");
    sample(400, 0, "R6");
    sample(-200, 0, "R6");
    sample(-200, 0, "R6");

    // R2 and R3: back-to-back offers, coefficient change while busy is ignored
    do_reset();
    set_coef(4096, 512, 1024, 2048);
    for (int i = 0; i < 5; i++) begin
      offer(100 * i - 150, 20 * i, "R2");
      set_coef(4096 + 1000 * i, 512, 1024, 2048);
      repeat (2) do_cycle("R2");
    end
    in_valid = 1'b0;
    drain("R3");

    // R7 and R8: saturation both ways and integral freeze
    do_reset();
    set_coef(16384, 4096, 0, 0);
    for (int i = 0; i < 3; i++) sample(10000, 0, "R7");
    sample(-1000, 0, "R8");
    sample(-10000, 0, "R7");
    sample(0, 20, "R8");

    // R9: derivative state pushed into its clamp, then decayed into view
    do_reset();
    set_coef(0, 0, 32000, 4096);
    for (int i = 0; i < 8; i++) sample(1000, 0, "R9");
    set_coef(0, 0, 2048, 4096);
    for (int i = 0; i < 14; i++) sample(1000, 0, "R9");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule